// File: doc/BRIEF.md
# Transmit System Biframe Alignment Tracker

The block sits on the system side of a transmit framer. System data that supplies the spare bits of time slot 0 must also carry a two-frame marker. One bit of the time slot 0 octet is set to 1 in a frame whose spare bits go to a NOT FAS line frame. It is set to 0 in the next frame, whose spare bits go to a FAS line frame. The tracker samples that marker once per system frame, when the frame strobe is high. While the alternation holds, it reports alignment and tells the line side which line frame type the current system frame feeds.

Any break in the alternation drops the tracker into a loss state and produces a one-cycle loss event. In the loss state it hunts for a fresh 1-then-0 frame pair. When it finds one, it produces a realignment event and resumes tracking. A restart pulse forces a new hunt from any state. Software applies it before switching to transparent spare-bit transfer. During loss, a corrupt-enable flag tells the line side to spoil outgoing data, but only when the system interface is the source of the spare bits.

Top module: `biframe_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, aligned, fasPhase, lossEvent and realignEvent are all 0, so the tracker starts in the loss state with an empty hunt history.
- R2: The marker is ts0Octet bit index MARK_BIT (default 6, the second most significant bit, with bit 7 as the most significant). The other octet bits, and the octet in any cycle without frameStrobe, have no effect on any output.
- R3: In the loss state, aligned rises in the cycle after a strobed frame whose marker is 0, if the strobed frame just before it since loss was entered had marker 1. The hunt history is empty each time loss is entered.
- R4: realignEvent is a one-cycle pulse in the same cycle that aligned rises, and at no other time.
- R5: While aligned, each strobed frame must carry the opposite marker to the previous accepted frame. A repeated marker clears aligned in the next cycle and raises lossEvent for that one cycle.
- R6: restartReq clears aligned and the hunt history in the next cycle and takes priority over a strobe in the same cycle. It raises lossEvent only if the tracker was aligned.
- R7: fasPhase is 1 exactly when aligned is 1 and the last accepted strobed frame had marker 0. It is 0 in the loss state.
- R8: corruptEn equals (not aligned) AND sysSourced, and it follows sysSourced within the same cycle.
- R9: Without frameStrobe and restartReq, aligned, fasPhase and both events keep the values given by the previous cycle's rules, so aligned holds and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStrobe | input | 1 | Marks the cycle in which ts0Octet holds a frame's time slot 0 octet |
| ts0Octet | input | OCTET_W | Time slot 0 octet of the system transmit frame |
| sysSourced | input | 1 | High when the system interface sources the spare bits |
| restartReq | input | 1 | One-cycle pulse that forces a new hunt |
| aligned | output | 1 | Biframe alignment held |
| lossEvent | output | 1 | One-cycle pulse on entry to the loss state |
| realignEvent | output | 1 | One-cycle pulse when alignment is regained |
| fasPhase | output | 1 | 1: current system frame feeds a FAS line frame; 0: NOT FAS or loss |
| corruptEn | output | 1 | Spoil line data now |

## Verification
Alignment state, phase and both events are registered. They are due in the first cycle after the strobe or restart that causes them. corruptEn is combinational and is due in the same cycle as a change of sysSourced. The bench updates its behavioural model at each rising edge from the inputs driven at the previous falling edge. It compares every output 2 ns after that edge, so each registered result is checked in exactly the cycle it is due, and corruptEn is checked against the sysSourced value present at that moment.

// File: rtl/biframe_pkg.sv
package biframe_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic huntClr;   // empty the hunt history
    logic huntLoad;  // record this frame's marker as hunt history
    logic trackAdv;  // accept frame into tracking (expectation and phase)
    logic phaseClr;  // force phase output low
  } bfCtl_t;

  typedef enum logic {
    ST_LOSS    = 1'b0,
    ST_ALIGNED = 1'b1
  } bfState_t;

endpackage

// File: rtl/bf_datapath.sv
module bf_datapath
  import biframe_pkg::*;
#(
  parameter int OCTET_W  = 8,
  parameter int MARK_BIT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OCTET_W-1:0] ts0Octet,
  input  bfCtl_t             ctl,
  output logic               markBit,
  output logic               matchExp,
  output logic               huntHit,
  output logic               fasPhase
);

  logic prevOne;   // last hunted frame carried marker 1
  logic expMark;   // marker expected on next accepted frame

  assign markBit  = ts0Octet[MARK_BIT];
  assign matchExp = (markBit == expMark);
  assign huntHit  = prevOne && !markBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOne <= 1'b0;
    end else if (ctl.huntClr) begin
      prevOne <= 1'b0;
    end else if (ctl.huntLoad) begin
      prevOne <= markBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expMark  <= 1'b0;
      fasPhase <= 1'b0;
    end else if (ctl.trackAdv) begin
      expMark  <= !markBit;
      fasPhase <= !markBit;
    end else if (ctl.phaseClr) begin
      fasPhase <= 1'b0;
    end
  end

  // R3
  hunt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.huntClr |=> !huntHit);

endmodule

// File: rtl/bf_control.sv
module bf_control
  import biframe_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameStrobe,
  input  logic   restartReq,
  input  logic   matchExp,
  input  logic   huntHit,
  output bfCtl_t ctl,
  output logic   aligned,
  output logic   lossEvent,
  output logic   realignEvent
);

  bfState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (restartReq) begin
      nextState    = ST_LOSS;
      ctl.huntClr  = 1'b1;
      ctl.phaseClr = 1'b1;
    end else if (frameStrobe) begin
      if (state == ST_LOSS) begin
        if (huntHit) begin
          nextState    = ST_ALIGNED;
          ctl.trackAdv = 1'b1;
          ctl.huntClr  = 1'b1;
        end else begin
          ctl.huntLoad = 1'b1;
        end
      end else if (matchExp) begin
        ctl.trackAdv = 1'b1;
      end else begin
        nextState    = ST_LOSS;
        ctl.huntClr  = 1'b1;
        ctl.phaseClr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_LOSS;
      lossEvent    <= 1'b0;
      realignEvent <= 1'b0;
    end else begin
      state        <= nextState;
      lossEvent    <= (state == ST_ALIGNED) && (nextState == ST_LOSS);
      realignEvent <= (state == ST_LOSS) && (nextState == ST_ALIGNED);
    end
  end

  assign aligned = (state == ST_ALIGNED);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStrobe && !restartReq) |=> $stable(aligned));

  // R6
  restart_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !aligned);

  // R4
  realign_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    realignEvent |-> (aligned && !$past(aligned)));

  // R5
  loss_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossEvent |-> (!aligned && $past(aligned)));

  // R4
  event_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lossEvent, realignEvent}));

endmodule

// File: rtl/biframe_tracker.sv
module biframe_tracker
  import biframe_pkg::*;
#(
  parameter int OCTET_W  = 8,
  parameter int MARK_BIT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStrobe,
  input  logic [OCTET_W-1:0] ts0Octet,
  input  logic               sysSourced,
  input  logic               restartReq,
  output logic               aligned,
  output logic               lossEvent,
  output logic               realignEvent,
  output logic               fasPhase,
  output logic               corruptEn
);

  bfCtl_t ctl;
  logic   markBit;
  logic   matchExp;
  logic   huntHit;

  bf_datapath #(
    .OCTET_W (OCTET_W),
    .MARK_BIT(MARK_BIT)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ts0Octet(ts0Octet),
    .ctl     (ctl),
    .markBit (markBit),
    .matchExp(matchExp),
    .huntHit (huntHit),
    .fasPhase(fasPhase)
  );

  bf_control ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .frameStrobe (frameStrobe),
    .restartReq  (restartReq),
    .matchExp    (matchExp),
    .huntHit     (huntHit),
    .ctl         (ctl),
    .aligned     (aligned),
    .lossEvent   (lossEvent),
    .realignEvent(realignEvent)
  );

  assign corruptEn = !aligned && sysSourced;

  // R7
  phase_in_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    fasPhase |-> aligned);

  // R3
  rise_has_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aligned) |-> realignEvent);

  // R7
  phase_after_realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    realignEvent |-> fasPhase);

endmodule

// File: tb/biframe_tracker_tb_top.sv
module biframe_tracker_tb_top;

  localparam int OW = 8;
  localparam int MB = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameStrobe = 1'b0;
  logic [OW-1:0] ts0Octet = '0;
  logic          sysSourced = 1'b0;
  logic          restartReq = 1'b0;
  logic          aligned, lossEvent, realignEvent, fasPhase, corruptEn;

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;

  // behavioural reference state
  int mAligned = 0;
  int mLast    = 0;
  int mPhase   = 0;
  int mLossEv  = 0;
  int mReEv    = 0;
  int huntQ[$];

  always #5 clk = ~clk;

  biframe_tracker #(.OCTET_W(OW), .MARK_BIT(MB)) dut_i (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .ts0Octet(ts0Octet),
    .sysSourced(sysSourced), .restartReq(restartReq), .aligned(aligned),
    .lossEvent(lossEvent), .realignEvent(realignEvent), .fasPhase(fasPhase),
    .corruptEn(corruptEn)
  );

  task automatic check(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic enterLoss();
    if (mAligned != 0) mLossEv = 1;
    mAligned = 0;
    mPhase   = 0;
    huntQ.delete();
  endtask

  // model update on the edge, compare 2 ns later
  always @(posedge clk) begin
    int mk;
    mLossEv = 0;
    mReEv   = 0;
    if (!rstN) begin
      mAligned = 0; mPhase = 0; mLast = 0;
      huntQ.delete();
    end else if (restartReq) begin
      enterLoss();                       // R6 priority over strobe
    end else if (frameStrobe) begin
      mk = int'(ts0Octet[MB]);
      if (mAligned != 0) begin
        if (mk == mLast) enterLoss();    // R5
        else begin mLast = mk; mPhase = (mk == 0) ? 1 : 0; end
      end else begin
        huntQ.push_back(mk);
        if (huntQ.size() >= 2 && huntQ[huntQ.size()-2] == 1 && huntQ[huntQ.size()-1] == 0) begin
          mAligned = 1; mReEv = 1; mLast = 0; mPhase = 1;  // R3
          huntQ.delete();
        end
      end
    end
    #2;
    if (running) begin
      check("R3/R5/R6/R9", "aligned", int'(aligned), mAligned);
      check("R5", "lossEvent", int'(lossEvent), mLossEv);
      check("R4", "realignEvent", int'(realignEvent), mReEv);
      check("R7", "fasPhase", int'(fasPhase), mPhase);
      check("R8", "corruptEn", int'(corruptEn), (mAligned == 0 && sysSourced) ? 1 : 0);
    end
  end

  // R2: non-marker bits random, marker forced
  task automatic sendFrame(bit mk, int gap);
    @(negedge clk);
    frameStrobe = 1'b1;
    ts0Octet = OW'($urandom);
    ts0Octet[MB] = mk;
    @(negedge clk);
    frameStrobe = 1'b0;
    ts0Octet = OW'($urandom);            // R2: ignored without strobe
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulseRestart(bit withStrobe, bit mk);
    @(negedge clk);
    restartReq = 1'b1;
    frameStrobe = withStrobe;
    ts0Octet = OW'($urandom);
    ts0Octet[MB] = mk;
    @(negedge clk);
    restartReq = 1'b0;
    frameStrobe = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    running = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state during and just after reset
    check("R1", "aligned in reset", int'(aligned), 0);
    check("R1", "fasPhase in reset", int'(fasPhase), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "aligned after reset", int'(aligned), 0);
    check("R1", "events after reset", int'(lossEvent | realignEvent), 0);

    // R3: hunt 0,0,1,1,0 then track, back-to-back and gapped
    sendFrame(0, 0); sendFrame(0, 2); sendFrame(1, 0); sendFrame(1, 1); sendFrame(0, 3);
    for (int i = 0; i < 6; i++) sendFrame(i % 2 == 0, i % 3);
    // R8: corruptEn while aligned and during loss
    sysSourced = 1'b1;
    sendFrame(1, 1);
    // R5: repeated marker breaks alignment
    sendFrame(1, 2);
    // R3: the breaking frame is not hunt history, so a 0 here stays lost
    sendFrame(0, 1);
    sendFrame(1, 0); sendFrame(0, 2);
    sysSourced = 1'b0;
    // R5: break by a repeated 0
    sendFrame(1, 0); sendFrame(0, 0);
    sendFrame(0, 2);
    sendFrame(1, 0); sendFrame(0, 1);
    // R6: restart while aligned, then hunt history cleared across restart
    pulseRestart(1'b0, 1'b0);
    sendFrame(1, 0);
    pulseRestart(1'b0, 1'b0);
    sendFrame(0, 1);
    sendFrame(1, 0); sendFrame(0, 1);
    // R6: restart with a strobe in the same cycle that would have matched
    sendFrame(1, 0);
    pulseRestart(1'b1, 1'b0);
    // R6: restart while already lost
    pulseRestart(1'b0, 1'b1);
    sysSourced = 1'b1;
    repeat (4) @(negedge clk);          // R9 idle hold
    sendFrame(1, 0); sendFrame(0, 0);
    repeat (5) @(negedge clk);
    sysSourced = 1'b0;
    for (int i = 0; i < 40; i++) sendFrame(($urandom % 4) != 0 ? (i % 2 == 1) : bit'($urandom), $urandom % 3);
    repeat (4) @(negedge clk);
    running = 1'b0;
    finishRun();
  end

endmodule